// File: doc/BRIEF.md
# Execute-Stage Forwarding Register Controller

This block manages the result register that sits at the end of the execute stage of each function unit. Software can name that register directly as a forwarding register. A source operand that carries such a name picks up the last result of the selected unit. A destination that carries such a name keeps the result in the unit's register and does not write it to the register file. The register changes only when a real instruction updates it. NOPs, stalls, invalid slots and loads leave it untouched, so a value can be forwarded several cycles after it was produced.

Conventional forwarding by register-number comparison runs alongside the named path. A source that names a register-file index equal to a result now being written back is bypassed from that unit's register. A load cannot target a forwarding register, because load data never passes through the execute result register. Such an instruction is flagged and has no effect.

Register specifiers are 6 bits wide. Bit 5 set means a forwarding-register name, and the low bit(s) select the unit. Bit 5 clear means a register-file index in bits 4:0. Operand-select kinds are encoded as 0 = register file, 1 = explicit forwarding register, 2 = automatic bypass.

Top module: `fwd_ctrl`

## Requirements
- R1: An instruction updates its unit's result register at the clock edge when it is valid, is not a NOP, is not a load, and no stall is active. pipe_en_o is high during that cycle, and the result appears on fwd_data_o in the next cycle.
- R2: When pipe_en_o is low (invalid slot, NOP, load or stall), the unit's result register keeps its value unchanged.
- R3: An update whose destination has bit 5 set stores the result in the unit's register, but rf_we_o for that unit stays low in the following cycle.
- R4: An update whose destination has bit 5 clear raises rf_we_o in the following cycle, with rf_waddr_o equal to destination bits 4:0.
- R5: A source spec with bit 5 set gives kind 1 (explicit), with the unit number taken from the low spec bit.
- R6: A source spec with bit 5 clear whose bits 4:0 equal rf_waddr_o of a unit with rf_we_o high gives kind 2 (automatic) and that unit. When several units match, the lowest-numbered unit wins.
- R7: Any other source spec gives kind 0 (register file) and unit 0.
- R8: An explicit name takes priority: a spec with bit 5 set gives kind 1 even when its bits 4:0 match an active write-back index.
- R9: A valid, non-NOP load with no stall and a destination that has bit 5 set raises illegal_o in that same cycle. It does not update the result register and causes no register-file write.
- R10: While reset is held, every result register reads zero and no rf_we_o is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Interlock; freezes all result registers |
| valid_i | input | N_FU | Instruction present per unit |
| nop_i | input | N_FU | Instruction is a NOP |
| load_i | input | N_FU | Instruction is a load |
| dst_i | input | N_FU x 6 | Destination spec |
| src_a_i | input | N_FU x 6 | First source spec |
| src_b_i | input | N_FU x 6 | Second source spec |
| result_i | input | N_FU x DW | Execute result bus per unit |
| a_kind_o | output | N_FU x 2 | First operand select kind |
| a_unit_o | output | N_FU x UW | First operand source unit |
| b_kind_o | output | N_FU x 2 | Second operand select kind |
| b_unit_o | output | N_FU x UW | Second operand source unit |
| fwd_data_o | output | N_FU x DW | Result register contents per unit |
| pipe_en_o | output | N_FU | Result register clock enable |
| rf_we_o | output | N_FU | Register-file write enable from write-back |
| rf_waddr_o | output | N_FU x 5 | Register-file write index |
| illegal_o | output | N_FU | Load targeting a forwarding register |

## Verification
The first sweep drives both units through every combination of valid, NOP, load, stall and destination kind. Each unit gets a different pattern, and every result value is distinct. This separates a real update from a frozen register, a suppressed write-back from a normal one, and an illegal load from a harmless one. The second sweep presents all 64 source specs on both operands against three write-back setups: two units writing different indices, one unit whose destination is a forwarding register, and two units writing the same index. This tells explicit selection, automatic bypass, lowest-unit priority and the register-file fallback apart.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF   = 2'd0,
    SEL_EXPL = 2'd1,
    SEL_AUTO = 2'd2
  } sel_kind_e;
endpackage

// File: rtl/fwd_ex_reg.sv
module fwd_ex_reg #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          fwd_dst_i,
  input  logic [RW-1:0] dst_idx_i,
  input  logic [DW-1:0] res_i,
  output logic [DW-1:0] data_o,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o
);
  logic [DW-1:0] data_q;
  logic          wb_vld_q, wb_rf_q;
  logic [RW-1:0] wb_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      wb_vld_q <= 1'b0;
      wb_rf_q  <= 1'b0;
      wb_idx_q <= '0;
    end else begin
      wb_vld_q <= en_i;
      if (en_i) begin
        data_q   <= res_i;
        wb_rf_q  <= ~fwd_dst_i;
        wb_idx_q <= dst_idx_i;
      end
    end
  end

  assign data_o     = data_q;
  assign rf_we_o    = wb_vld_q & wb_rf_q;
  assign rf_waddr_o = wb_idx_q;

  a_r1_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> data_o == $past(res_i));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(data_o));
  a_r3_no_rf_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && fwd_dst_i) |=> !rf_we_o);
  a_r4_rf_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fwd_dst_i) |=> (rf_we_o && rf_waddr_o == $past(dst_idx_i)));
endmodule

// File: rtl/fwd_src_sel.sv
module fwd_src_sel
  import fwd_pkg::*;
#(
  parameter int N_FU = 2,
  parameter int RW   = 5,
  parameter int UW   = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [RW:0]              src_i,
  input  logic [N_FU-1:0]          rf_we_i,
  input  logic [N_FU-1:0][RW-1:0]  rf_waddr_i,
  output logic [1:0]               kind_o,
  output logic [UW-1:0]            unit_o
);
  sel_kind_e kind;

  always_comb begin
    kind   = SEL_RF;
    unit_o = '0;
    if (src_i[RW]) begin
      kind   = SEL_EXPL;
      unit_o = src_i[UW-1:0];
    end else begin
      // descending scan: lowest matching unit wins
      for (int k = N_FU - 1; k >= 0; k--) begin
        if (rf_we_i[k] && rf_waddr_i[k] == src_i[RW-1:0]) begin
          kind   = SEL_AUTO;
          unit_o = UW'(k);
        end
      end
    end
  end

  assign kind_o = kind;

  a_r6_auto_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == SEL_AUTO) |-> (rf_we_i[unit_o] && rf_waddr_i[unit_o] == src_i[RW-1:0]));
  a_r8_expl_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_i[RW] |-> (kind_o == SEL_EXPL));
  a_r7_rf_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_i[RW] && rf_we_i == '0) |-> (kind_o == SEL_RF));
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl #(
  parameter int N_FU = 2,   // power of two
  parameter int DW   = 32,
  parameter int RW   = 5,
  localparam int UW  = (N_FU > 1) ? $clog2(N_FU) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     stall_i,
  input  logic [N_FU-1:0]          valid_i,
  input  logic [N_FU-1:0]          nop_i,
  input  logic [N_FU-1:0]          load_i,
  input  logic [N_FU-1:0][RW:0]    dst_i,
  input  logic [N_FU-1:0][RW:0]    src_a_i,
  input  logic [N_FU-1:0][RW:0]    src_b_i,
  input  logic [N_FU-1:0][DW-1:0]  result_i,
  output logic [N_FU-1:0][1:0]     a_kind_o,
  output logic [N_FU-1:0][UW-1:0]  a_unit_o,
  output logic [N_FU-1:0][1:0]     b_kind_o,
  output logic [N_FU-1:0][UW-1:0]  b_unit_o,
  output logic [N_FU-1:0][DW-1:0]  fwd_data_o,
  output logic [N_FU-1:0]          pipe_en_o,
  output logic [N_FU-1:0]          rf_we_o,
  output logic [N_FU-1:0][RW-1:0]  rf_waddr_o,
  output logic [N_FU-1:0]          illegal_o
);
  for (genvar u = 0; u < N_FU; u++) begin : g_fu
    logic issue;
    assign issue        = valid_i[u] & ~nop_i[u] & ~stall_i;
    assign pipe_en_o[u] = issue & ~load_i[u];
    assign illegal_o[u] = issue & load_i[u] & dst_i[u][RW];

    fwd_ex_reg #(.DW(DW), .RW(RW)) u_ex (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (pipe_en_o[u]),
      .fwd_dst_i  (dst_i[u][RW]),
      .dst_idx_i  (dst_i[u][RW-1:0]),
      .res_i      (result_i[u]),
      .data_o     (fwd_data_o[u]),
      .rf_we_o    (rf_we_o[u]),
      .rf_waddr_o (rf_waddr_o[u])
    );

    fwd_src_sel #(.N_FU(N_FU), .RW(RW), .UW(UW)) u_sel_a (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_a_i[u]),
      .rf_we_i    (rf_we_o),
      .rf_waddr_i (rf_waddr_o),
      .kind_o     (a_kind_o[u]),
      .unit_o     (a_unit_o[u])
    );

    fwd_src_sel #(.N_FU(N_FU), .RW(RW), .UW(UW)) u_sel_b (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_b_i[u]),
      .rf_we_i    (rf_we_o),
      .rf_waddr_i (rf_waddr_o),
      .kind_o     (b_kind_o[u]),
      .unit_o     (b_unit_o[u])
    );

    a_r9_illegal_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o[u] |=> !rf_we_o[u]);
    a_r9_illegal_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o[u] |=> $stable(fwd_data_o[u]));
  end

  always_comb begin
    a_r10_reset_quiet: assert (rst_ni || rf_we_o == '0);
  end
endmodule

// File: tb/tb_fwd_ctrl.sv
module tb_fwd_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic stall;
  logic [1:0] valid, nop, load;
  logic [1:0][5:0] dst, src_a, src_b;
  logic [1:0][31:0] result;
  logic [1:0][1:0] a_kind, b_kind;
  logic [1:0][0:0] a_unit, b_unit;
  logic [1:0][31:0] fwd_data;
  logic [1:0] pipe_en, rf_we, illegal;
  logic [1:0][4:0] rf_waddr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] e_fwd [2];
  bit          e_we  [2];
  logic [4:0]  e_wa  [2];
  string       t_fwd [2];
  string       t_we  [2];

  always #4 clk = ~clk;

  fwd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall),
    .valid_i(valid), .nop_i(nop), .load_i(load),
    .dst_i(dst), .src_a_i(src_a), .src_b_i(src_b), .result_i(result),
    .a_kind_o(a_kind), .a_unit_o(a_unit), .b_kind_o(b_kind), .b_unit_o(b_unit),
    .fwd_data_o(fwd_data), .pipe_en_o(pipe_en), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .illegal_o(illegal)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_sel(input logic [5:0] s, input int var_i, output string tag);
    if (s[5]) begin
      tag = "R5";
      if ((var_i == 0 && (s[4:0] == 5'd7 || s[4:0] == 5'd12)) ||
          (var_i == 1 && s[4:0] == 5'd7) || (var_i == 2 && s[4:0] == 5'd9))
        tag = "R8";
      return {2'd1, s[0]};
    end
    if (var_i == 0 && s[4:0] == 5'd7)  begin tag = "R6"; return {2'd2, 1'b0}; end
    if (var_i == 0 && s[4:0] == 5'd12) begin tag = "R6"; return {2'd2, 1'b1}; end
    if (var_i == 1 && s[4:0] == 5'd7)  begin tag = "R6"; return {2'd2, 1'b0}; end
    if (var_i == 2 && s[4:0] == 5'd9)  begin tag = "R6"; return {2'd2, 1'b0}; end
    tag = "R7";
    return 3'b000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall = 1'b0; valid = '0; nop = '0; load = '0;
    dst = '0; src_a = '0; src_b = '0; result = '0;
    repeat (3) @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      chk(fwd_data[u] == 32'h0, "R10 fwd_data", fwd_data[u], 0);
      chk(rf_we[u] == 1'b0, "R10 rf_we", rf_we[u], 0);
      e_fwd[u] = '0; e_we[u] = 1'b0; e_wa[u] = '0;
      t_fwd[u] = "R10"; t_we[u] = "R10";
    end
    rst_n = 1'b1;

    // sweep 1: control flag combinations on both units
    for (int it = 0; it < 257; it++) begin
      logic [7:0] c;
      c = 8'(it);
      @(negedge clk);
      for (int u = 0; u < 2; u++) begin
        chk(fwd_data[u] == e_fwd[u], t_fwd[u], fwd_data[u], e_fwd[u]);
        chk(rf_we[u] == e_we[u], t_we[u], rf_we[u], e_we[u]);
        if (e_we[u]) chk(rf_waddr[u] == e_wa[u], "R4 waddr", rf_waddr[u], e_wa[u]);
      end
      stall = c[7];
      valid = {c[3], c[0]};
      nop   = {c[4], c[1]};
      load  = {c[5], c[2]};
      for (int u = 0; u < 2; u++) begin
        dst[u]    = {c[6], 5'((it + u * 3) & 31)};
        result[u] = 32'hA000_0000 + 32'(it * 2 + u);
      end
      #1;
      for (int u = 0; u < 2; u++) begin
        bit en, ill;
        en  = valid[u] & ~nop[u] & ~load[u] & ~stall;
        ill = valid[u] & ~nop[u] & load[u] & ~stall & dst[u][5];
        chk(pipe_en[u] == en, en ? "R1 pipe_en" : "R2 pipe_en", pipe_en[u], en);
        chk(illegal[u] == ill, "R9 illegal", illegal[u], ill);
        if (en) begin
          e_fwd[u] = result[u];
          t_fwd[u] = "R1 capture";
        end else
          t_fwd[u] = ill ? "R9 no update" : "R2 hold";
        e_we[u] = en & ~dst[u][5];
        e_wa[u] = dst[u][4:0];
        t_we[u] = ill ? "R9 no write" : (en && dst[u][5]) ? "R3 suppressed" : "R4 rf_we";
      end
    end

    // sweep 2: every source spec against three write-back setups
    for (int v = 0; v < 3; v++) begin
      for (int s = 0; s < 64; s++) begin
        @(negedge clk);
        stall = 1'b0; valid = 2'b11; nop = '0; load = '0;
        src_a = '0; src_b = '0;
        result = {32'h1111_0000 + 32'(s), 32'h2222_0000 + 32'(s)};
        case (v)
          0: begin dst[0] = {1'b0, 5'd7}; dst[1] = {1'b0, 5'd12}; end
          1: begin dst[0] = {1'b0, 5'd7}; dst[1] = {1'b1, 5'd12}; end
          default: begin dst[0] = {1'b0, 5'd9}; dst[1] = {1'b0, 5'd9}; end
        endcase
        @(negedge clk);
        valid = '0;
        for (int u = 0; u < 2; u++) begin
          src_b[u] = 6'(s);
          src_a[u] = 6'(s) ^ 6'h20;
        end
        #1;
        for (int u = 0; u < 2; u++) begin
          string ta, tb;
          logic [2:0] ea, eb;
          ea = exp_sel(src_a[u], v, ta);
          eb = exp_sel(src_b[u], v, tb);
          chk({a_kind[u], a_unit[u]} == ea, {ta, " opA"}, {a_kind[u], a_unit[u]}, ea);
          chk({b_kind[u], b_unit[u]} == eb, {tb, " opB"}, {b_kind[u], b_unit[u]}, eb);
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule